// File: doc/BRIEF.md
# Grouped External Interrupt Controller

This block accepts sixteen asynchronous interrupt request lines from outside the chip and turns them into three interrupt requests for a parent interrupt controller. Each line is brought into the clock domain through a two-stage synchroniser. It is then checked against a trigger type shared with its neighbouring line. The trigger can be a level of either polarity or an edge of either or both directions. Each detected event is held in a pending bit until software acknowledges it.

A mask register decides which pending bits may reach the outputs. The sixteen lines are split into three groups of unequal size: lines 0–3, lines 4–11 and lines 12–15. Each group drives one registered output, which is high while any pending, unmasked line of that group exists.

Software reaches the block through a small register bus with four word addresses:

- Address 0 gives a read-only view of the packed trigger configuration.
- Address 1 is the pending register, which is cleared by writing ones.
- Address 2 is the mask register.
- Address 3 is a write-only command that sets the trigger of one line.

Top module: `xint_group_ctrl`

## Requirements
- R1: During and directly after reset, the configuration view reads 0, pending reads 0, mask reads 0x0000FFFF and all three group outputs are low.
- R2: A write to address 3 carries a line index in wdata[4:0] and a trigger code in wdata[10:8]. It replaces only bits (n/2)*4 to (n/2)*4+2 of the configuration view, so lines 2k and 2k+1 share one code. An index of 16 or more, or a write to address 0, leaves the configuration unchanged.
- R3: Code 3'b100 detects rising edges, 3'b010 falling edges and 3'b110 both edges of the synchronised input.
- R4: Code 3'b000 records an event on every cycle the synchronised input is low, and 3'b001 on every cycle it is high. Clearing the pending bit of a line whose active level is still present leaves the bit set.
- R5: Codes 3'b011, 3'b101 and 3'b111 never set a pending bit.
- R6: Writing to address 1 clears each pending bit whose wdata bit is 1. Bits written 0 keep their value. Address 1 reads the pending bits in [15:0].
- R7: When an event and a clear of the same pending bit fall in one cycle, the bit remains set.
- R8: Address 2 holds the mask in [15:0], where 1 blocks a line from its group output. A masked line still records pending events.
- R9: Output grp_irq[0] reflects lines 0–3, grp_irq[1] lines 4–11 and grp_irq[2] lines 12–15. Each output is high one cycle after any line of its group is pending and unmasked.
- R10: An input change made between two clock edges shows in the pending register after the third following rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 16 | Asynchronous external interrupt lines |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 2 | Word address: 0 configuration, 1 pending, 2 mask, 3 trigger-set |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| grp_irq | output | 3 | Registered grouped interrupt requests |

## Verification
The hardest case to reach is an edge event that arrives in exactly the same cycle as a clear of its own pending bit. From the ports, that cycle can only be hit by counting the synchroniser and detector stages. The bench changes a line half a cycle after an edge and asserts the clear strobe so that it is sampled on the third following edge. It then repeats the clear one cycle later to show the bit does fall once the edge has passed. Level persistence is provoked in a similar way: lines are held at their active level while every pending bit is cleared.

// File: rtl/xint_pkg.sv
// Shared constants and types for the grouped external interrupt controller.
// Assumes sixteen lines, a 32-bit register bus and three fixed line groups.
package xint_pkg;
    localparam int NUM_LINES    = 16;
    localparam int IDX_W        = 5;
    localparam int CODE_W       = 3;
    localparam int CODE_LSB     = 8;
    localparam int FIELD_STRIDE = 4;
    localparam int NUM_FIELDS   = NUM_LINES / 2;
    localparam int CFG_W        = NUM_FIELDS * FIELD_STRIDE;
    localparam int DATA_W       = 32;
    localparam int ADDR_W       = 2;
    localparam int NUM_GROUPS   = 3;
    localparam int GRP_LO [NUM_GROUPS] = '{0, 4, 12};
    localparam int GRP_HI [NUM_GROUPS] = '{3, 11, 15};

    typedef enum logic [ADDR_W-1:0] {
        REG_CFG      = 2'd0,
        REG_PEND     = 2'd1,
        REG_MASK     = 2'd2,
        REG_TRIG_SET = 2'd3
    } reg_addr_e;

    typedef enum logic [CODE_W-1:0] {
        TRIG_LOW  = 3'b000,
        TRIG_HIGH = 3'b001,
        TRIG_FALL = 3'b010,
        TRIG_RISE = 3'b100,
        TRIG_BOTH = 3'b110
    } trig_e;

    // Builds a line-select vector covering lines lo..hi inclusive.
    function automatic logic [NUM_LINES-1:0] span_mask(input int lo, input int hi);
        logic [NUM_LINES-1:0] m;
        m = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (i >= lo && i <= hi) m[i] = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/xint_sync.sv
// Two-stage synchroniser for a vector of asynchronous lines.
// Assumes each bit is independent; no cross-bit coherence is provided.
module xint_sync #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stable_q;

    // Shift each line through two flops into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q   <= '0;
            stable_q <= '0;
        end else begin
            meta_q   <= async_in;
            stable_q <= meta_q;
        end
    end

    assign sync_out = stable_q;
endmodule

// File: rtl/xint_detect.sv
// Per-line event detector: applies the trigger code to one synchronised line.
// Assumes lvl is already synchronous; edges compare against last cycle's value.
module xint_detect
    import xint_pkg::*;
#(
    parameter int CW = CODE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lvl,
    input  logic [CW-1:0] code,
    output logic          evt
);
    logic prev_q;
    logic rise;
    logic fall;

    // Remember the previous synchronised value for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;
    assign fall = ~lvl & prev_q;

    // Select the event condition named by the trigger code.
    always_comb begin
        case (code)
            TRIG_LOW:  evt = ~lvl;
            TRIG_HIGH: evt = lvl;
            TRIG_FALL: evt = fall;
            TRIG_RISE: evt = rise;
            TRIG_BOTH: evt = rise | fall;
            default:   evt = 1'b0;
        endcase
    end

    // R5: undefined codes never produce an event.
    assert_reserved_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (code == 3'b011 || code == 3'b101 || code == 3'b111) |-> !evt);
endmodule

// File: rtl/xint_regs.sv
// Register file: packed trigger configuration, pending bits and mask bits.
// Assumes a single-cycle write strobe and combinational read data.
module xint_regs
    import xint_pkg::*;
#(
    parameter int N  = NUM_LINES,
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W,
    parameter int CW = CFG_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [N-1:0]  evt,
    output logic [CW-1:0] cfg_q,
    output logic [N-1:0]  pend_q,
    output logic [N-1:0]  mask_q
);
    localparam int NF = CW / FIELD_STRIDE;

    logic [IDX_W-1:0]  set_idx;
    logic [CODE_W-1:0] set_code;
    logic              set_hit;
    logic [CW-1:0]     cfg_next;
    logic [N-1:0]      ack;
    logic              unused_hi;

    assign set_idx   = bus_wdata[IDX_W-1:0];
    assign set_code  = bus_wdata[CODE_LSB +: CODE_W];
    assign set_hit   = bus_wr && (bus_addr == REG_TRIG_SET) && (int'(set_idx) < N);
    assign ack       = (bus_wr && bus_addr == REG_PEND) ? bus_wdata[N-1:0] : '0;
    assign unused_hi = ^bus_wdata[DW-1:N];

    // Replace only the field owned by the addressed line pair.
    always_comb begin
        cfg_next = cfg_q;
        for (int f = 0; f < NF; f++) begin
            if (set_hit && int'(set_idx[IDX_W-1:1]) == f)
                cfg_next[f*FIELD_STRIDE +: CODE_W] = set_code;
        end
    end

    // Update configuration, pending and mask state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            pend_q <= '0;
            mask_q <= '1;
        end else begin
            cfg_q  <= cfg_next;
            pend_q <= (pend_q & ~ack) | evt;
            if (bus_wr && bus_addr == REG_MASK) mask_q <= bus_wdata[N-1:0];
        end
    end

    // Return the addressed register, zero-extended to the bus width.
    always_comb begin
        case (bus_addr)
            REG_CFG:  bus_rdata = DW'(cfg_q);
            REG_PEND: bus_rdata = DW'(pend_q);
            REG_MASK: bus_rdata = DW'(mask_q);
            default:  bus_rdata = '0;
        endcase
    end

    // R2: out-of-range trigger-set commands leave the configuration intact.
    assert_cfg_reject_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_TRIG_SET && int'(bus_wdata[IDX_W-1:0]) >= N) |=> $stable(cfg_q));

    // R6: a pending bit only rises when its line produced an event.
    assert_no_spurious_pend_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((pend_q & ~$past(pend_q) & ~$past(evt)) == '0));

    // R7: an event in the same cycle as a clear keeps the bit pending.
    assert_event_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((~pend_q & $past(evt)) == '0));
endmodule

// File: rtl/xint_group_ctrl.sv
// Top level: synchronises sixteen lines, detects events per trigger code,
// holds pending/mask state and drives three registered grouped requests.
// Assumes irq_in is asynchronous and the bus is in the clk domain.
module xint_group_ctrl
    import xint_pkg::*;
#(
    parameter int N  = NUM_LINES,
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W,
    parameter int NG = NUM_GROUPS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  irq_in,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic [NG-1:0] grp_irq
);
    localparam int CW = (N / 2) * FIELD_STRIDE;

    logic [N-1:0]  sync_lvl;
    logic [N-1:0]  evt;
    logic [CW-1:0] cfg_q;
    logic [N-1:0]  pend_q;
    logic [N-1:0]  mask_q;
    logic [N-1:0]  live;
    logic [NG-1:0] grp_q;
    logic          unused_cfg;

    xint_sync #(.WIDTH(N)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (irq_in),
        .sync_out (sync_lvl)
    );

    for (genvar n = 0; n < N; n++) begin : g_line
        xint_detect #(.CW(CODE_W)) u_det (
            .clk   (clk),
            .rst_n (rst_n),
            .lvl   (sync_lvl[n]),
            .code  (cfg_q[(n/2)*FIELD_STRIDE +: CODE_W]),
            .evt   (evt[n])
        );
    end

    xint_regs #(.N(N), .DW(DW), .AW(AW), .CW(CW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .evt       (evt),
        .cfg_q     (cfg_q),
        .pend_q    (pend_q),
        .mask_q    (mask_q)
    );

    assign live       = pend_q & ~mask_q;
    assign unused_cfg = ^cfg_q;

    for (genvar g = 0; g < NG; g++) begin : g_grp
        localparam logic [N-1:0] SEL = span_mask(GRP_LO[g], GRP_HI[g]);

        // Register the OR of this group's live pending lines.
        always_ff @(posedge clk) begin
            if (!rst_n) grp_q[g] <= 1'b0;
            else        grp_q[g] <= |(live & SEL);
        end

        // R9: a pending unmasked line of the group raises its output next cycle.
        assert_group_raise_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (|(pend_q & ~mask_q & SEL)) |=> grp_irq[g]);
    end

    assign grp_irq = grp_q;

    // R8: with every line masked, no group output rises.
    assert_masked_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_q) |=> (grp_irq == '0));
endmodule

// File: tb/xint_group_ctrl_tb.sv
module xint_group_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_in = '0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  grp_irq;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    xint_group_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .grp_irq(grp_irq)
    );

    typedef struct packed {
        logic [2:0]  code;
        logic [15:0] pre;
        logic [15:0] post;
        logic [15:0] mask;
        logic [15:0] pend;
        logic [2:0]  grp;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{3'b100, 16'h0000, 16'h00F3, 16'h0000, 16'h00F3, 3'b011},
        '{3'b010, 16'hFFFF, 16'h0F0F, 16'h0000, 16'hF0F0, 3'b110},
        '{3'b110, 16'h00FF, 16'h0F0F, 16'h0000, 16'h0FF0, 3'b010},
        '{3'b001, 16'h0000, 16'h8001, 16'h0001, 16'h8001, 3'b100},
        '{3'b000, 16'hFFFF, 16'hFFF0, 16'h0000, 16'h000F, 3'b001},
        '{3'b011, 16'h0000, 16'hFFFF, 16'h0000, 16'h0000, 3'b000},
        '{3'b100, 16'h0000, 16'h1008, 16'h0000, 16'h1008, 3'b101},
        '{3'b100, 16'h0000, 16'h0810, 16'h0000, 16'h0810, 3'b010},
        '{3'b100, 16'h0000, 16'hFFFF, 16'hFFFF, 16'hFFFF, 3'b000}
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic set_trig(input int line, input logic [2:0] code);
        bus_write(2'd3, {21'd0, code, 3'd0, 5'(line)});
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] rd;
        step(3);
        // R1: reset state observed while reset is held.
        bus_read(2'd0, rd); check("R1 cfg", rd, 32'h0);
        bus_read(2'd1, rd); check("R1 pend", rd, 32'h0);
        bus_read(2'd2, rd); check("R1 mask", rd, 32'h0000FFFF);
        check("R1 grp", {29'd0, grp_irq}, 32'h0);
        rst_n = 1'b1;
        step(1);
        check("R1 grp after release", {29'd0, grp_irq}, 32'h0);
        // R4: default low-level code with idle-low inputs marks every line pending.
        step(3);
        bus_read(2'd1, rd); check("R4 low level after reset", rd, 32'h0000FFFF);
        check("R8 all masked grp", {29'd0, grp_irq}, 32'h0);

        // Vector table: R3 R4 R5 R8 R9 R10.
        for (int v = 0; v < NV; v++) begin
            for (int p = 0; p < 8; p++) set_trig(2 * p, VECS[v].code);
            bus_read(2'd0, rd);
            check("R2 cfg replicate", rd, {8{1'b0, VECS[v].code}});
            irq_in = VECS[v].pre;
            step(4);
            bus_write(2'd1, 32'h0000FFFF);
            bus_write(2'd2, {16'd0, VECS[v].mask});
            irq_in = VECS[v].post;
            step(5);
            bus_read(2'd1, rd);
            check("R3/R4/R5 pend vector", rd, {16'd0, VECS[v].pend});
            check("R9 grp vector", {29'd0, grp_irq}, {29'd0, VECS[v].grp});
        end

        // R10: pending appears only after the third edge.
        bus_write(2'd2, 32'h0000FFFF);
        irq_in = 16'h0000;
        step(4);
        bus_write(2'd1, 32'h0000FFFF);
        irq_in = 16'h0004;
        step(2);
        bus_read(2'd1, rd); check("R10 not yet after two edges", rd, 32'h0);
        step(1);
        bus_read(2'd1, rd); check("R10 set after third edge", rd, 32'h00000004);
        irq_in = 16'hFFFF;
        step(5);

        // R2: field isolation, rejected index and ignored config write.
        set_trig(5, 3'b001);
        bus_read(2'd0, rd); check("R2 line5 field", rd, 32'h44444144);
        set_trig(16, 3'b010);
        bus_read(2'd0, rd); check("R2 index16 rejected", rd, 32'h44444144);
        set_trig(31, 3'b110);
        bus_read(2'd0, rd); check("R2 index31 rejected", rd, 32'h44444144);
        bus_write(2'd0, 32'h0);
        bus_read(2'd0, rd); check("R2 addr0 write ignored", rd, 32'h44444144);
        set_trig(15, 3'b110);
        bus_read(2'd0, rd); check("R2 line15 field", rd, 32'h64444144);
        set_trig(15, 3'b100);

        // R6: write-zero keeps bits, write-one clears; R4 held levels re-pend.
        step(4);
        bus_read(2'd1, rd); check("R6 pend before ack", rd, 32'h0000FFFF);
        bus_write(2'd1, 32'h0);
        bus_read(2'd1, rd); check("R6 zero write no effect", rd, 32'h0000FFFF);
        bus_write(2'd1, 32'h000000F0);
        bus_read(2'd1, rd); check("R6 partial clear", rd, 32'h0000FF3F);
        bus_write(2'd1, 32'h0000FFFF);
        bus_read(2'd1, rd); check("R4 held level survives clear", rd, 32'h00000030);

        // R8/R9: unmask lines 4,5 only; group 1 rises one cycle later.
        check("R8 masked grp quiet", {29'd0, grp_irq}, 32'h0);
        bus_write(2'd2, 32'h0000FFCF);
        check("R9 grp not yet", {29'd0, grp_irq}, 32'h0);
        step(1);
        check("R9 grp1 from lines 4,5", {29'd0, grp_irq}, 32'h2);

        // R7: edge event and clear in the same cycle.
        irq_in = 16'h0000;
        step(4);
        bus_write(2'd1, 32'h0000FFFF);
        bus_read(2'd1, rd); check("R7 setup clear", rd, 32'h0);
        irq_in = 16'h0100;
        step(2);
        bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 32'h0000FFFF;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
        bus_read(2'd1, rd); check("R7 event beats clear", rd, 32'h00000100);
        bus_write(2'd1, 32'h00000100);
        bus_read(2'd1, rd); check("R6 later clear succeeds", rd, 32'h0);

        summary();
        $finish;
    end
endmodule